// File: doc/BRIEF.md
# Receiver Error Interrupt Status Register

This block gathers eight conditions reported by a digital audio receiver (AES3 / S/PDIF style) into one read-only status byte and pairs it with a read/write mask byte of the same layout. It drives one interrupt line. Two bits are error flags. An error flag latches an event and holds it until software reads the status byte. The other six bits are live levels. A live level raises a request only when its value moves away from the value it had at the last status read, or at reset if there has been no read yet.

Software reaches the block through a plain register bus with an address, read strobe, write strobe, write data and read data. A read of the status byte clears every pending request and takes a new reference for each live level. A read of the mask byte has no side effect. The stream decoding logic that produces the condition inputs sits outside this block.

Top module: `rx_err_irq_reg`

## Requirements
- R1: Reset is synchronous and active low. After reset the mask byte reads 0x00, both error flags read 0 and `irq` is 0.
- R2: A read at address 0x18 returns the status byte. Address 0x19 holds the mask byte and can be both written and read. A read at any other address returns 0x00. A read returns data combinationally in the cycle `reg_rd` is high. A write to any address other than 0x19, including 0x18, changes no register.
- R3: Status bit positions: 7 validity, 6 emphasis, 5 nonaudio, 4 nonaudio-preamble, 3 CRC error, 2 no-stream, 1 biphase/parity error, 0 PLL lock. Bits 7, 6, 5, 4, 2 and 0 show the present level of their inputs.
- R4: The CRC error bit (3) and the biphase/parity bit (1) set on a one-cycle event pulse. Each stays 1 until a status read, and reads 0 after that read if no new event has arrived.
- R5: An error event in the same cycle as a status read leaves its bit set and its request pending after the read.
- R6: A level bit becomes pending when its input differs from its reference. The reference is the value at the last status read, or at reset. The bit stays pending until the next status read, even if the input returns to the reference value. A status read clears the pending state and takes the present value as the new reference.
- R7: The nonaudio bit becomes pending when the nonaudio input changes. It also becomes pending when the nonaudio input is 1 and the 2-bit nonaudio type code differs from the code seen at the reference point. A type change while the data is audio (nonaudio input 0) is ignored.
- R8: `irq` is 1 exactly when some bit is pending and its mask bit is 1. A mask bit of 0 blocks that bit from the interrupt.
- R9: A read of the mask byte, or of an unmapped address, clears no pending request and no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 7 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| rx_validity | input | 1 | Validity level of received stream |
| rx_emphasis | input | 1 | Pre-emphasis present |
| rx_nonaudio | input | 1 | Channel-status nonaudio flag |
| rx_na_kind | input | 2 | Nonaudio data type code |
| rx_preamble_na | input | 1 | Nonaudio detected through a preamble |
| rx_crc_err | input | 1 | Channel-status CRC error event pulse |
| rx_nostream | input | 1 | No input stream present |
| rx_biphase_err | input | 1 | Biphase or parity error event pulse |
| rx_pll_lock | input | 1 | PLL locked level |
| irq | output | 1 | Interrupt request |

## Verification
Two kinds of internal fault show at the ports. A wrong reference or pending flag shows on `irq` in the cycle after the condition edge, provided the matching mask bit is set. A wrong error flag shows in the next status read. The bench checks `irq` on every cycle against a model that tracks references, pending flags and flags from the requirements alone, so a fault shows up on the first masked cycle it affects. Directed cases cover the situations random traffic rarely reaches: an event arriving in the same cycle as a read, type changes while the data is audio, and writes to the read-only address.

// File: rtl/rxe_pkg.sv
// Package: shared constants for the receiver error interrupt register.
// Assumes an 8-bit status layout that software decodes by bit position.
package rxe_pkg;
    localparam int NBITS    = 8;
    localparam int BIT_LOCK = 0;
    localparam int BIT_BIPH = 1;
    localparam int BIT_NOST = 2;
    localparam int BIT_CRC  = 3;
    localparam int BIT_PRE  = 4;
    localparam int BIT_NA   = 5;
    localparam int BIT_EMPH = 6;
    localparam int BIT_VAL  = 7;

    typedef enum logic [1:0] {KIND_LEVEL, KIND_STICKY, KIND_NONAUDIO} bit_kind_e;

    function automatic bit_kind_e kind_of(input int idx);
        if (idx == BIT_CRC || idx == BIT_BIPH) return KIND_STICKY;
        if (idx == BIT_NA) return KIND_NONAUDIO;
        return KIND_LEVEL;
    endfunction
endpackage

// File: rtl/rxe_sticky.sv
// Sticky error flag: set by an event pulse, cleared by a status read.
// Assumes clr_i is a single-cycle read strobe; an event in the read cycle wins.
module rxe_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic evt_i,
    output logic flag_o
);
    logic flag_q;

    // Latch events; a read reloads the flag with the current event.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (clr_i) flag_q <= evt_i;
        else if (evt_i) flag_q <= 1'b1;
    end

    assign flag_o = flag_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (flag_q && !clr_i) |=> flag_q); // R4
    AST_EVENT_KEPT:  assert property (@(posedge clk) disable iff (!rst_n) evt_i |=> flag_q); // R5
endmodule

// File: rtl/rxe_level_track.sv
// Change detector for a level condition: flags pending once the key differs
// from the reference taken at the last read (or during reset).
// Assumes key_i is synchronous to clk.
module rxe_level_track #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] key_i,
    output logic         pend_o
);
    logic [W-1:0] ref_q;
    logic         pend_q;

    // Reference follows the key in reset and at each read; pending latches a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ref_q  <= key_i;
            pend_q <= 1'b0;
        end else if (key_i != ref_q) begin
            pend_q <= 1'b1;
        end
    end

    assign pend_o = pend_q;

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pend_q && !clr_i) |=> pend_q); // R6
endmodule

// File: rtl/rxe_bus.sv
// Register bus slice: address decode, mask register and read data mux.
// Assumes single-cycle strobes; read data is combinational while reg_rd is high.
module rxe_bus #(
    parameter int          ADDR_W    = 7,
    parameter int          DATA_W    = 8,
    parameter logic [6:0]  STAT_ADDR = 7'h18,
    parameter logic [6:0]  MASK_ADDR = 7'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              stat_rd_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    logic [DATA_W-1:0] mask_q;

    // Mask register: cleared by reset, loaded by a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mask_q <= '0;
        else if (wr_i && addr_i == A_MASK)  mask_q <= wdata_i;
    end

    // Read data mux.
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (addr_i == A_STAT)      rdata_o = status_i;
            else if (addr_i == A_MASK) rdata_o = mask_q;
        end
    end

    assign mask_o    = mask_q;
    assign stat_rd_o = rd_i && (addr_i == A_STAT);

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_i && addr_i == A_MASK) |=> $stable(mask_q)); // R2
endmodule

// File: rtl/rx_err_irq_reg.sv
// Receiver error interrupt status register: eight receiver conditions, a mask
// byte and one interrupt line. Bits 3 and 1 are sticky errors; the rest are
// live levels that interrupt on change since the last status read.
// Assumes all condition inputs are synchronous to clk.
module rx_err_irq_reg
    import rxe_pkg::*;
#(
    parameter int          ADDR_W    = 7,
    parameter int          KIND_W    = 2,
    parameter logic [6:0]  STAT_ADDR = 7'h18,
    parameter logic [6:0]  MASK_ADDR = 7'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              rx_validity,
    input  logic              rx_emphasis,
    input  logic              rx_nonaudio,
    input  logic [KIND_W-1:0] rx_na_kind,
    input  logic              rx_preamble_na,
    input  logic              rx_crc_err,
    input  logic              rx_nostream,
    input  logic              rx_biphase_err,
    input  logic              rx_pll_lock,
    output logic              irq
);
    localparam int NA_KEY_W = KIND_W + 1;

    logic [NBITS-1:0]    live;
    logic [NBITS-1:0]    evt;
    logic [NBITS-1:0]    status;
    logic [NBITS-1:0]    pend;
    logic [NBITS-1:0]    mask;
    logic                stat_rd;
    logic [NA_KEY_W-1:0] na_key;

    // Gather the raw condition levels and event pulses by bit position.
    always_comb begin
        live           = '0;
        live[BIT_VAL]  = rx_validity;
        live[BIT_EMPH] = rx_emphasis;
        live[BIT_NA]   = rx_nonaudio;
        live[BIT_PRE]  = rx_preamble_na;
        live[BIT_NOST] = rx_nostream;
        live[BIT_LOCK] = rx_pll_lock;
        evt            = '0;
        evt[BIT_CRC]   = rx_crc_err;
        evt[BIT_BIPH]  = rx_biphase_err;
    end

    // Nonaudio key: the type code only counts while the data is nonaudio.
    assign na_key = {rx_nonaudio ? rx_na_kind : {KIND_W{1'b0}}, rx_nonaudio};

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (kind_of(i) == KIND_STICKY) begin : g_sticky
            rxe_sticky u_flag (
                .clk(clk), .rst_n(rst_n), .clr_i(stat_rd),
                .evt_i(evt[i]), .flag_o(pend[i])
            );
            assign status[i] = pend[i];
        end else if (kind_of(i) == KIND_NONAUDIO) begin : g_na
            rxe_level_track #(.W(NA_KEY_W)) u_trk (
                .clk(clk), .rst_n(rst_n), .clr_i(stat_rd),
                .key_i(na_key), .pend_o(pend[i])
            );
            assign status[i] = live[i];
        end else begin : g_level
            rxe_level_track #(.W(1)) u_trk (
                .clk(clk), .rst_n(rst_n), .clr_i(stat_rd),
                .key_i(live[i]), .pend_o(pend[i])
            );
            assign status[i] = live[i];
        end
    end

    rxe_bus #(
        .ADDR_W(ADDR_W), .DATA_W(NBITS),
        .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .rd_i(reg_rd),
        .wr_i(reg_wr), .wdata_i(reg_wdata), .status_i(status),
        .mask_o(mask), .rdata_o(reg_rdata), .stat_rd_o(stat_rd)
    );

    assign irq = |(pend & mask);

    AST_READ_QUIETS: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && evt == '0) |=> !irq); // R6
endmodule

// File: tb/sim_rx_err_irq_reg.sv
// Bench: random traffic plus directed corners, checked against a bench model.
module sim_rx_err_irq_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_validity = 0, rx_emphasis = 0, rx_nonaudio = 0;
    logic [1:0] rx_na_kind = 0;
    logic       rx_preamble_na = 0, rx_crc_err = 0, rx_nostream = 0;
    logic       rx_biphase_err = 0, rx_pll_lock = 0;
    logic       irq;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    // Bench model state
    logic [7:0] m_mask, m_pend, m_ref;
    logic [1:0] m_ref_kind;
    logic       m_crc, m_biph;

    always #5 clk = ~clk;

    rx_err_irq_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_validity(rx_validity), .rx_emphasis(rx_emphasis),
        .rx_nonaudio(rx_nonaudio), .rx_na_kind(rx_na_kind),
        .rx_preamble_na(rx_preamble_na), .rx_crc_err(rx_crc_err),
        .rx_nostream(rx_nostream), .rx_biphase_err(rx_biphase_err),
        .rx_pll_lock(rx_pll_lock), .irq(irq)
    );

    function automatic logic [7:0] levels();
        return {rx_validity, rx_emphasis, rx_nonaudio, rx_preamble_na,
                1'b0, rx_nostream, 1'b0, rx_pll_lock};
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] s = levels();
        s[3] = m_crc;
        s[1] = m_biph;
        return s;
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (!reg_rd)            return 8'h00;
        if (reg_addr == 7'h18)  return exp_status();
        if (reg_addr == 7'h19)  return m_mask;
        return 8'h00;
    endfunction

    function automatic logic exp_irq();
        logic [7:0] p = m_pend;
        p[3] = m_crc;
        p[1] = m_biph;
        return |(p & m_mask);
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Update the model as the flops will at the coming edge.
    task automatic model_edge();
        logic [7:0] lv = levels();
        logic       srd = reg_rd && reg_addr == 7'h18;
        if (!rst_n) begin
            m_mask = 0; m_pend = 0; m_crc = 0; m_biph = 0;
            m_ref = lv; m_ref_kind = rx_nonaudio ? rx_na_kind : 2'b00;
        end else begin
            if (reg_wr && reg_addr == 7'h19) m_mask = reg_wdata;
            if (srd) begin
                m_pend = 0; m_ref = lv; m_ref_kind = rx_nonaudio ? rx_na_kind : 2'b00;
                m_crc = rx_crc_err; m_biph = rx_biphase_err;
            end else begin
                for (int i = 0; i < 8; i++)
                    if (i != 3 && i != 1 && lv[i] != m_ref[i]) m_pend[i] = 1'b1;
                if ((rx_nonaudio ? rx_na_kind : 2'b00) != m_ref_kind) m_pend[5] = 1'b1;
                if (rx_crc_err)     m_crc = 1'b1;
                if (rx_biphase_err) m_biph = 1'b1;
            end
        end
    endtask

    // One cycle: inputs already set at negedge; check, update model, advance.
    task automatic step(input string tag);
        #1;
        if (rst_n) begin
            check8({tag, " R8 irq"}, {7'd0, irq}, {7'd0, exp_irq()});
            if (reg_rd) check8({tag, " R2/R3 rdata"}, reg_rdata, exp_rdata());
        end
        model_edge();
        @(negedge clk);
        reg_rd = 0; reg_wr = 0; rx_crc_err = 0; rx_biphase_err = 0;
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        reg_addr = a; reg_rd = 1; step(tag);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d, input string tag);
        reg_addr = a; reg_wr = 1; reg_wdata = d; step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        rx_pll_lock = 1; rx_nostream = 0;
        repeat (3) step("reset");
        rst_n = 1;
        // R1: reset state
        reg_addr = 7'h19; reg_rd = 1; #1;
        check8("R1 mask after reset", reg_rdata, 8'h00);
        check8("R1 irq after reset", {7'd0, irq}, 8'h00);
        step("R1");
        reg_addr = 7'h18; reg_rd = 1; #1;
        check8("R1 error flags after reset", reg_rdata & 8'h0A, 8'h00);
        step("R1");
        // R6: levels equal to reset reference raise nothing
        wr(7'h19, 8'hFF, "R6");
        step("R6 no change");
        check8("R6 no pending from reset levels", {7'd0, irq}, 8'h00);
        // R2: write to status address ignored; unmapped read returns 0
        wr(7'h18, 8'h00, "R2");
        wr(7'h05, 8'h00, "R2");
        rd(7'h19, "R2 mask kept");
        rd(7'h05, "R2 unmapped");
        // R4: sticky CRC error holds, clears on read
        rx_crc_err = 1; step("R4");
        step("R4"); step("R4");
        check8("R4 crc irq held", {7'd0, irq}, 8'h01);
        rd(7'h19, "R9 mask read");
        check8("R9 mask read keeps irq", {7'd0, irq}, 8'h01);
        rd(7'h18, "R4 read clears");
        check8("R4 irq after read", {7'd0, irq}, 8'h00);
        // R5: biphase event in the read cycle is kept
        rx_biphase_err = 1; rd(7'h18, "R5");
        check8("R5 event kept irq", {7'd0, irq}, 8'h01);
        rd(7'h18, "R5 flag visible");
        // R7: type change while audio is ignored
        rx_na_kind = 2'd2; step("R7"); step("R7");
        check8("R7 kind change audio ignored", {7'd0, irq}, 8'h00);
        rx_nonaudio = 1; step("R7"); step("R7");
        check8("R7 nonaudio rise", {7'd0, irq}, 8'h01);
        rd(7'h18, "R7");
        rx_na_kind = 2'd1; step("R7"); step("R7");
        check8("R7 kind change nonaudio", {7'd0, irq}, 8'h01);
        rd(7'h18, "R7");
        // R6: toggle and return still pending
        rx_emphasis = 1; step("R6"); rx_emphasis = 0; step("R6"); step("R6");
        check8("R6 pending after return", {7'd0, irq}, 8'h01);
        rd(7'h18, "R6");
        // R8: masked bit does not interrupt
        wr(7'h19, 8'hBF, "R8");
        rx_emphasis = 1; step("R8"); step("R8");
        check8("R8 masked emphasis", {7'd0, irq}, 8'h00);
        // Random traffic, R3 read data checked inside step
        for (int c = 0; c < 4000; c++) begin
            int r;
            if ($urandom % 8 == 0) begin
                case ($urandom % 6)
                    0: rx_validity    = ~rx_validity;
                    1: rx_emphasis    = ~rx_emphasis;
                    2: rx_nonaudio    = ~rx_nonaudio;
                    3: rx_preamble_na = ~rx_preamble_na;
                    4: rx_nostream    = ~rx_nostream;
                    default: rx_pll_lock = ~rx_pll_lock;
                endcase
            end
            if ($urandom % 10 == 0) rx_na_kind = 2'($urandom);
            rx_crc_err     = ($urandom % 25 == 0);
            rx_biphase_err = ($urandom % 25 == 0);
            r = $urandom % 16;
            if (r < 3)       begin reg_addr = 7'h18; reg_rd = 1; end
            else if (r == 3) begin reg_addr = 7'h19; reg_rd = 1; end
            else if (r == 4) begin reg_addr = 7'h19; reg_wr = 1; reg_wdata = 8'($urandom); end
            else if (r == 5) begin reg_addr = 7'($urandom); reg_rd = 1; end
            else if (r == 6) begin reg_addr = 7'h18; reg_wr = 1; reg_wdata = 8'($urandom); end
            step("R3 random");
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule